// File: doc/BRIEF.md
# Multi-Format Pixel Output Packer

This block takes decoded video samples and places them on a 16-pin parallel pixel bus in one of four fixed pin layouts. Two layouts carry 4:2:2 YCbCr: a byte-wide layout that sends one sample per output clock on the upper byte, and a word-wide layout that sends luma and chroma side by side. The other two carry RGB, as 5-5-5 or as 5-6-5. A registered data-valid flag marks the words that carry picture data. Every other output cycle carries a fixed blanking word.

Upstream samples arrive on a valid/ready stream. One beat is either a 4:2:2 pixel pair (Cb, Y0, Cr, Y1) or a single RGB pixel. The packer takes a new beat only when it has finished emitting the previous one. The byte-wide mode therefore accepts at most one beat every four cycles, the word-wide YCbCr mode one every two cycles, and the RGB modes one per cycle. The upstream side may hold `s_valid_i` low at any time. A beat transfers on a rising clock edge where `s_valid_i` and `s_ready_o` are both high. While valid is high the beat fields must stay steady until that edge. A slot that finds no beat emits blanking.

The control pins are plain levels. `active_i` gates the output to active video. `line_start_i` is a one-cycle pulse at the start of each scan line: it loads a new output mode and restarts the sample order.

Top module: `pop_pixel_packer`

## Requirements
- R1: While reset is asserted and after it is released, the bus reads 0x1000, the valid flag is low and the latched mode is the byte-wide YCbCr mode.
- R2: Mode code 0 (byte-wide YCbCr) emits the samples of each accepted pair in the order Cb, Y0, Cr, Y1 on bus bits 15:8, one sample per cycle, with bit 8 as the LSB. Bits 7:0 are zero. The cycle after a beat is accepted, `s_ready_o` is low.
- R3: A line-start cycle accepts no beat, and the output registered from it is blanking. Any unsent samples of a partial pair are discarded, so the first valid word after a line start is always a Cb sample.
- R4: Mode code 1 (word-wide YCbCr) emits {Y0, Cb} and then {Y1, Cr}: luma on bits 15:8 and chroma on bits 7:0.
- R5: Mode code 2 (RGB 5-5-5) emits red on bits 14:10, green input bits 5:1 on bits 9:5 and blue on bits 4:0. Bit 15 is zero. One pixel is sent per cycle.
- R6: Mode code 3 (RGB 5-6-5) emits red on bits 15:11, green on bits 10:5 and blue on bits 4:0. One pixel is sent per cycle.
- R7: When `active_i` is low, or when a beat slot finds no valid beat, the valid flag is low and the bus carries the blanking word of the latched mode: 0x1000 for mode 0, 0x1080 for mode 1, and 0x0000 for modes 2 and 3.
- R8: `mode_i` is sampled only in a line-start cycle. Changes at any other time have no effect on the bus.
- R9: `s_ready_o` is high exactly when `active_i` is high, `line_start_i` is low and no sample of a previously accepted beat remains to be sent. Unsent samples are held while `active_i` is low, and they resume when it returns high.
- R10: Each output word appears on the bus one clock edge after the edge that takes its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Output layout code, loaded at line start |
| line_start_i | input | 1 | One-cycle pulse at the start of each scan line |
| active_i | input | 1 | High during active video |
| s_valid_i | input | 1 | Stream beat valid |
| s_ready_o | output | 1 | Stream beat ready |
| cb_i | input | 8 | Blue-difference sample of the pair |
| y0_i | input | 8 | First luma sample of the pair |
| cr_i | input | 8 | Red-difference sample of the pair |
| y1_i | input | 8 | Second luma sample of the pair |
| red_i | input | 5 | Red component of an RGB beat |
| green_i | input | 6 | Green component of an RGB beat |
| blue_i | input | 5 | Blue component of an RGB beat |
| pix_o | output | 16 | Parallel pixel bus |
| pix_valid_o | output | 1 | Bus carries picture data |

## Verification
A wrong slot phase shows on the bus in the same output cycle. A luma byte appears where Cb is due, a line's first word is not chroma, or `s_ready_o` opens during a pair that has not finished, so an extra beat is swallowed. A wrong latched mode shows on the first valid word or blanking word after the faulty line start, because the lane layout and the blanking code both change. A lost or stale held sample shows one to three cycles after the beat is accepted, when its slot is emitted. The bench model compares bus, flag and ready on every cycle, so each of these faults is caught in the cycle it first reaches a port.

// File: rtl/pop_pkg.sv
package pop_pkg;

  typedef enum logic [1:0] {
    OM_YC8    = 2'd0,
    OM_YC16   = 2'd1,
    OM_RGB555 = 2'd2,
    OM_RGB565 = 2'd3
  } outmode_e;

  // Number of output cycles one accepted beat occupies in each layout
  function automatic logic [2:0] slots_per_beat(outmode_e m);
    case (m)
      OM_YC8:  return 3'd4;
      OM_YC16: return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/pop_mode_latch.sv
module pop_mode_latch
  import pop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_start_i,
  input  logic [1:0] mode_i,
  output outmode_e   mode_q_o,
  output outmode_e   mode_eff_o
);

  outmode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           mode_q <= OM_YC8;
    else if (line_start_i) mode_q <= outmode_e'(mode_i);
  end

  // During a line-start cycle the blanking word already follows the new mode
  assign mode_eff_o = line_start_i ? outmode_e'(mode_i) : mode_q;
  assign mode_q_o   = mode_q;

endmodule

// File: rtl/pop_slot_seq.sv
module pop_slot_seq
  import pop_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  outmode_e        mode_i,
  input  logic            line_start_i,
  input  logic            active_i,
  input  logic            s_valid_i,
  output logic            s_ready_o,
  output logic            load_o,
  output logic            emit_o,
  output logic [PH_W-1:0] slot_o
);

  logic [PH_W-1:0] phase_q;
  logic [2:0]      spb;
  logic            open_slot;
  logic            last_slot;

  assign spb       = slots_per_beat(mode_i);
  assign open_slot = active_i && !line_start_i;
  assign s_ready_o = open_slot && (phase_q == '0);
  assign load_o    = s_ready_o && s_valid_i;
  assign emit_o    = load_o || (open_slot && (phase_q != '0));
  assign last_slot = (3'(phase_q) + 3'd1) == spb;
  assign slot_o    = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           phase_q <= '0;
    else if (line_start_i) phase_q <= '0;
    else if (emit_o)       phase_q <= last_slot ? '0 : phase_q + 1'b1;
  end

endmodule

// File: rtl/pop_beat_hold.sv
module pop_beat_hold #(
  parameter int YC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [YC_W-1:0] y0_i,
  input  logic [YC_W-1:0] cr_i,
  input  logic [YC_W-1:0] y1_i,
  output logic [YC_W-1:0] y0_o,
  output logic [YC_W-1:0] cr_o,
  output logic [YC_W-1:0] y1_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y0_o <= '0;
      cr_o <= '0;
      y1_o <= '0;
    end else if (load_i) begin
      y0_o <= y0_i;
      cr_o <= cr_i;
      y1_o <= y1_i;
    end
  end

endmodule

// File: rtl/pop_lane_map.sv
module pop_lane_map
  import pop_pkg::*;
#(
  parameter int YC_W  = 8,
  parameter int RB_W  = 5,
  parameter int G_W   = 6,
  parameter int PH_W  = 2,
  parameter int BUS_W = 2 * YC_W
) (
  input  outmode_e         mode_i,
  input  logic [PH_W-1:0]  slot_i,
  input  logic [YC_W-1:0]  cb_i,
  input  logic [YC_W-1:0]  y0_i,
  input  logic [YC_W-1:0]  h_y0_i,
  input  logic [YC_W-1:0]  h_cr_i,
  input  logic [YC_W-1:0]  h_y1_i,
  input  logic [RB_W-1:0]  red_i,
  input  logic [G_W-1:0]   green_i,
  input  logic [RB_W-1:0]  blue_i,
  output logic [BUS_W-1:0] word_o
);

  localparam int W565 = 2 * RB_W + G_W;
  localparam int W555 = W565 - 1;

  logic [YC_W-1:0]  byte_sel;
  logic [BUS_W-1:0] w_yc8, w_yc16, w_555, w_565;

  always_comb begin
    case (slot_i)
      2'd0:    byte_sel = cb_i;
      2'd1:    byte_sel = h_y0_i;
      2'd2:    byte_sel = h_cr_i;
      default: byte_sel = h_y1_i;
    endcase
  end

  assign w_yc8  = {byte_sel, {YC_W{1'b0}}};
  assign w_yc16 = (slot_i == '0) ? {y0_i, cb_i} : {h_y1_i, h_cr_i};

  generate
    if (W565 < BUS_W) begin : g_pad565
      assign w_565 = {{(BUS_W - W565){1'b0}}, red_i, green_i, blue_i};
    end else begin : g_full565
      assign w_565 = {red_i, green_i, blue_i};
    end
    // The 5-5-5 layout keeps the most significant green bits
    assign w_555 = {{(BUS_W - W555){1'b0}}, red_i, green_i[G_W-1:1], blue_i};
  endgenerate

  always_comb begin
    case (mode_i)
      OM_YC8:    word_o = w_yc8;
      OM_YC16:   word_o = w_yc16;
      OM_RGB555: word_o = w_555;
      default:   word_o = w_565;
    endcase
  end

endmodule

// File: rtl/pop_pixel_packer.sv
module pop_pixel_packer
  import pop_pkg::*;
#(
  parameter int YC_W = 8,
  parameter int RB_W = 5,
  parameter int G_W  = 6,
  localparam int BUS_W = 2 * YC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             line_start_i,
  input  logic             active_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [YC_W-1:0]  cb_i,
  input  logic [YC_W-1:0]  y0_i,
  input  logic [YC_W-1:0]  cr_i,
  input  logic [YC_W-1:0]  y1_i,
  input  logic [RB_W-1:0]  red_i,
  input  logic [G_W-1:0]   green_i,
  input  logic [RB_W-1:0]  blue_i,
  output logic [BUS_W-1:0] pix_o,
  output logic             pix_valid_o
);

  localparam int PH_W = 2;
  localparam logic [YC_W-1:0] Y_BLACK = YC_W'(16) << (YC_W - 8);
  localparam logic [YC_W-1:0] C_MID   = YC_W'(1) << (YC_W - 1);

  outmode_e         mode_q, mode_eff;
  logic             load, emit;
  logic [PH_W-1:0]  slot;
  logic [YC_W-1:0]  h_y0, h_cr, h_y1;
  logic [BUS_W-1:0] word, blank_word, pix_q;
  logic             valid_q;

  pop_mode_latch u_mode (
    .clk_i, .rst_ni, .line_start_i, .mode_i,
    .mode_q_o(mode_q), .mode_eff_o(mode_eff)
  );

  pop_slot_seq #(.PH_W(PH_W)) u_seq (
    .clk_i, .rst_ni, .mode_i(mode_q), .line_start_i, .active_i,
    .s_valid_i, .s_ready_o, .load_o(load), .emit_o(emit), .slot_o(slot)
  );

  pop_beat_hold #(.YC_W(YC_W)) u_hold (
    .clk_i, .rst_ni, .load_i(load), .y0_i, .cr_i, .y1_i,
    .y0_o(h_y0), .cr_o(h_cr), .y1_o(h_y1)
  );

  pop_lane_map #(.YC_W(YC_W), .RB_W(RB_W), .G_W(G_W), .PH_W(PH_W), .BUS_W(BUS_W)) u_map (
    .mode_i(mode_q), .slot_i(slot), .cb_i, .y0_i,
    .h_y0_i(h_y0), .h_cr_i(h_cr), .h_y1_i(h_y1),
    .red_i, .green_i, .blue_i, .word_o(word)
  );

  always_comb begin
    case (mode_eff)
      OM_YC8:  blank_word = {Y_BLACK, {YC_W{1'b0}}};
      OM_YC16: blank_word = {Y_BLACK, C_MID};
      default: blank_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q   <= {Y_BLACK, {YC_W{1'b0}}};
      valid_q <= 1'b0;
    end else begin
      pix_q   <= emit ? word : blank_word;
      valid_q <= emit;
    end
  end

  assign pix_o       = pix_q;
  assign pix_valid_o = valid_q;

endmodule

// File: rtl/pop_pixel_packer_chk.sv
module pop_pixel_packer_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             line_start_i,
  input logic             active_i,
  input logic             s_valid_i,
  input logic             s_ready_o,
  input logic [BUS_W-1:0] pix_o,
  input logic             pix_valid_o,
  input logic [1:0]       mode_q
);

  p_lowbyte_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && mode_q == 2'd0) |-> (pix_o[BUS_W/2-1:0] == '0));

  p_ready_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o && mode_q == 2'd0) |=> !s_ready_o);

  p_ls_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> !pix_valid_o);

  p_rgb555_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && mode_q == 2'd2) |-> !pix_o[BUS_W-1]);

  p_idle_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !pix_valid_o);

  p_mode_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(mode_q));

  p_ready_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i || line_start_i) |-> !s_ready_o);

endmodule

bind pop_pixel_packer pop_pixel_packer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
  .active_i(active_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
  .pix_o(pix_o), .pix_valid_o(pix_valid_o), .mode_q(mode_q)
);

// File: tb/pop_pixel_packer_tb_top.sv
module pop_pixel_packer_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic ls = 1'b0, act = 1'b0, svalid = 1'b0;
  logic sready;
  logic [7:0] cb = '0, y0 = '0, cr = '0, y1 = '0;
  logic [4:0] rd = '0, bl = '0;
  logic [5:0] gr = '0;
  logic [15:0] pix;
  logic pvalid;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pop_pixel_packer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .line_start_i(ls),
    .active_i(act), .s_valid_i(svalid), .s_ready_o(sready),
    .cb_i(cb), .y0_i(y0), .cr_i(cr), .y1_i(y1),
    .red_i(rd), .green_i(gr), .blue_i(bl),
    .pix_o(pix), .pix_valid_o(pvalid)
  );

  // Behavioural reference: a queue of words still owed for the current beat
  logic [15:0] pend[$];
  int          m_mode = 0;
  logic [15:0] e_pix = 16'h1000;
  bit          e_valid = 0;
  bit          first_after_ls = 0;
  string       e_tag = "R1";

  function automatic logic [15:0] blank_of(int m);
    if (m == 0) return 16'h1000;
    if (m == 1) return 16'h1080;
    return 16'h0000;
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend.delete(); m_mode = 0; e_pix = 16'h1000; e_valid = 0; e_tag = "R1";
    end else if (ls) begin
      pend.delete(); m_mode = int'(mode); e_valid = 0; e_pix = blank_of(m_mode);
      e_tag = "R3"; first_after_ls = 1;
    end else begin
      if (act && pend.size() == 0 && svalid) begin
        case (m_mode)
          0: begin pend.push_back({cb, 8'h00}); pend.push_back({y0, 8'h00});
                   pend.push_back({cr, 8'h00}); pend.push_back({y1, 8'h00}); end
          1: begin pend.push_back({y0, cb}); pend.push_back({y1, cr}); end
          2: pend.push_back({1'b0, rd, gr[5:1], bl});
          default: pend.push_back({rd, gr, bl});
        endcase
      end
      if (act && pend.size() > 0) begin
        e_pix = pend.pop_front(); e_valid = 1;
        e_tag = first_after_ls ? "R3" : (int'(mode) != m_mode) ? "R8" : mode_tag(m_mode);
        first_after_ls = 0;
      end else begin
        e_pix = blank_of(m_mode); e_valid = 0;
        e_tag = (int'(mode) != m_mode) ? "R8" : "R7";
      end
    end
  end

  task automatic check(string tag, string what, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  // One cycle: compare registered outputs (R10 latency), drive new inputs, compare ready
  task automatic cycle(int p_act, int p_valid, int p_ls, bit rand_mode, int lsmode);
    @(posedge clk);
    @(negedge clk);
    check(e_tag, "pix_o", int'(pix), int'(e_pix));
    check(e_tag, "pix_valid_o", int'(pvalid), int'(e_valid));
    act    = ($urandom_range(99) < p_act);
    svalid = ($urandom_range(99) < p_valid);
    ls     = ($urandom_range(99) < p_ls);
    if (ls) mode = (lsmode < 0) ? 2'($urandom_range(3)) : 2'(lsmode);
    else if (rand_mode) mode = 2'($urandom_range(3));
    {cb, y0, cr, y1} = $urandom;
    {rd, gr, bl} = 16'($urandom);
    #1;
    check("R9", "s_ready_o", int'(sready), int'(act && !ls && pend.size() == 0));
  endtask

  task automatic line_pulse(int m);
    @(negedge clk);
    ls = 1; mode = 2'(m); act = 0; svalid = 0;
    @(posedge clk);
    @(negedge clk);
    ls = 0;
    check("R3", "pix_valid_o after line start", int'(pvalid), 0);
    check("R7", "blank after line start", int'(pix), int'(blank_of(m)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset pix_o", int'(pix), 16'h1000);
    check("R1", "reset pix_valid_o", int'(pvalid), 0);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "post-reset pix_o", int'(pix), 16'h1000);
    check("R1", "post-reset ready", int'(sready), 0);

    // Each layout in turn: steady stream, then gaps, idle spans and mid-pair line starts
    for (int m = 0; m < 4; m++) begin
      line_pulse(m);
      for (int i = 0; i < 40; i++) cycle(100, 100, 0, 0, m);
      for (int i = 0; i < 300; i++) cycle(85, 70, 4, 0, m);
      // mode_i wanders between line starts: R8
      for (int i = 0; i < 200; i++) cycle(90, 80, 3, 1, m);
    end
    // Mixed layouts chosen at random line starts
    for (int i = 0; i < 2000; i++) cycle(85, 75, 3, 1, -1);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=0x0 expected=0x1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule